// File: doc/BRIEF.md
# Real-Time Clock Core with Write-Safe Time Setting

This block keeps wall-clock time (seconds, minutes, hours) from a 32.768 kHz clock enable. A binary prescaler of `PRESC_BITS` stages (15 by default) turns the enable into a once-per-second tick. That tick advances the BCD time counters and sets a 1 Hz interrupt flag in the same clock cycle, so software that handles the interrupt always sees time that has just advanced.

Software reaches the block through a small synchronous register bus. Through it, software can zero the prescaler, mask the 1 Hz interrupt, choose the register page, and load the time fields. The prescaler tick falls at the midpoint of its count. After software zeroes the prescaler, the first tick therefore arrives half a second later.

The safe way to set the time is as follows. Zero the prescaler, unmask the interrupt, wait for the first interrupt, then write the fields. A time write that lands on the tick cycle, or on the cycle after it, is discarded and reported in a sticky status bit.

Top module: `rtc_core`

## Requirements
- R1: After reset, all three time fields read 00, the control register reads 0x02 (interrupt masked, page 0, clear bit 0), the status register reads 0x00 and `irq` is low.
- R2: The prescaler advances only on cycles with `clk_en` high. A tick occurs on the enable that takes the count from 2^(PRESC_BITS-1)-1 to 2^(PRESC_BITS-1), so ticks follow each other every 2^PRESC_BITS enables.
- R3: Writing 1 to control bit 0 (address 3) makes that bit read 1 for one cycle and then 0. The prescaler is zero on the following cycle, and the first tick comes after 2^(PRESC_BITS-1) enables, which is half a second.
- R4: Seconds (address 0) and minutes (address 1) are packed BCD and count 00 to 59. Hours (address 2) is packed BCD and counts 00 to 23. On a tick, seconds increments, and a wrap carries into minutes and then into hours in the same cycle.
- R5: Status bit 0 (address 4) becomes 1 at the same clock edge that increments the seconds. Writing 1 to that bit clears it, and a tick in the same cycle wins over the clear.
- R6: Control bit 1 masks the interrupt (1 = masked). `irq` is high while status bit 0 is set and control bit 1 is 0.
- R7: When control bit 2 (the page bit) is 1, addresses 0 to 2 read 0x00 and writes to them are ignored. Control and status stay reachable.
- R8: A write to addresses 0 to 2 on page 0, on the tick cycle or on the cycle after it, is not committed and sets sticky status bit 1. Writing 1 to status bit 1 clears it.
- R9: A write to addresses 0 to 2 on page 0 outside that window commits the value. The value is masked to 7 bits for seconds and minutes and to 6 bits for hours, and reads back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | One-cycle pulse at 32.768 kHz that advances the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 sec, 1 min, 2 hour, 3 control, 4 status) |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr`, combinational |
| irq | output | 1 | 1 Hz interrupt request, level |

## Verification
A wrong prescaler count or tick point shows at the ports as a change in seconds or a set pending bit on the wrong clock edge. Because the bench counts every cycle after a prescaler clear, such a fault is caught within one tick period. A broken carry chain or BCD step shows as a wrong time readback on the first tick after a vector is loaded. A collision window that is too wide or too narrow shows at once, on the next read: either a legal write fails to read back, or a dropped write changes seconds and leaves the status bit clear.

// File: rtl/rtc_pkg.sv
// Package: shared constants, register map and BCD helpers for the RTC core.
// Assumes the time fields are stored as 8-bit packed BCD (tens in [7:4]).
package rtc_pkg;

    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int NUM_FIELDS = 3;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADR_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd4;

    // Control and status bit positions
    localparam int CTL_CLR  = 0;
    localparam int CTL_MASK = 1;
    localparam int CTL_PAGE = 2;
    localparam int STS_PEND = 0;
    localparam int STS_DROP = 1;

    typedef logic [7:0] bcd8_t;

    // Highest legal value of field idx (0 sec, 1 min, 2 hour)
    function automatic bcd8_t field_limit(int idx);
        return (idx == 2) ? 8'h23 : 8'h59;
    endfunction

    // Bits kept when software loads field idx
    function automatic bcd8_t field_mask(int idx);
        return (idx == 2) ? 8'h3F : 8'h7F;
    endfunction

    // Next value of a packed BCD counter that wraps after lim
    function automatic bcd8_t bcd_step(bcd8_t v, bcd8_t lim);
        bcd8_t r;
        if (v == lim)
            r = 8'h00;
        else if (v[3:0] >= 4'd9)
            r = {v[7:4] + 4'd1, 4'h0};
        else
            r = v + 8'd1;
        return r;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Module: binary prescaler that divides the 32.768 kHz enable to one tick
// per second. The tick fires when the count crosses its midpoint, so a clear
// to zero yields the first tick after half a period.
// Assumes clk_en is a single-cycle pulse; clr has priority over counting.
module rtc_prescaler #(
    parameter int PRESC_BITS = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_en,
    input  logic                  clr,
    output logic                  tick,
    output logic [PRESC_BITS-1:0] cnt
);

    localparam logic [PRESC_BITS-1:0] MID_LAST = {1'b0, {(PRESC_BITS-1){1'b1}}};

    // Tick on the enable that moves the count across the midpoint
    always_comb begin
        tick = clk_en && !clr && (cnt == MID_LAST);
    end

    // Prescaler count: reset, software clear, or advance on enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (clk_en)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/rtc_bcd_field.sv
// Module: one packed-BCD time field with wrap detection and a load port.
// Assumes load and inc never need to act in the same cycle (the register
// block suppresses loads on tick cycles); load has priority if they do.
module rtc_bcd_field
    import rtc_pkg::*;
#(
    parameter bcd8_t LIMIT = 8'h59,
    parameter bcd8_t MASK  = 8'h7F
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inc,
    input  logic  load,
    input  bcd8_t load_val,
    output bcd8_t value,
    output logic  wrap
);

    // Carry out when incrementing from the limit
    always_comb begin
        wrap = inc && (value == LIMIT);
    end

    // Field value: reset, software load, or BCD increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= 8'h00;
        else if (load)
            value <= load_val & MASK;
        else if (inc)
            value <= bcd_step(value, LIMIT);
    end

endmodule

// File: rtl/rtc_timekeeper.sv
// Module: seconds, minutes and hours fields chained by a same-cycle carry.
// Assumes tick is a single-cycle pulse from the prescaler.
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [NUM_FIELDS-1:0]  load,
    input  bcd8_t                  load_val,
    output bcd8_t [NUM_FIELDS-1:0] fields
);

    logic [NUM_FIELDS:0]   carry;
    logic [NUM_FIELDS-1:0] wrap;

    // Carry chain entry point
    always_comb begin
        carry[0] = tick;
    end

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
            localparam bcd8_t LIM = field_limit(i);
            localparam bcd8_t MSK = field_mask(i);

            rtc_bcd_field #(
                .LIMIT(LIM),
                .MASK (MSK)
            ) u_field (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc     (carry[i]),
                .load    (load[i]),
                .load_val(load_val),
                .value   (fields[i]),
                .wrap    (wrap[i])
            );

            // Forward this field's wrap as the next field's increment
            always_comb begin
                carry[i+1] = wrap[i];
            end
        end
    endgenerate

endmodule

// File: rtl/rtc_regs.sv
// Module: register bank and bus decode. Holds control (prescaler clear,
// interrupt mask, page) and status (pending, dropped write), detects writes
// that collide with a tick, and muxes read data.
// Assumes a single-cycle write strobe and combinational reads.
module rtc_regs
    import rtc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   tick,
    input  bcd8_t [NUM_FIELDS-1:0] fields,
    output logic                   presc_clr,
    output logic                   irq_mask,
    output logic                   page,
    output logic                   pend,
    output logic                   drop,
    output logic [NUM_FIELDS-1:0]  field_load,
    output logic [DATA_W-1:0]      rdata
);

    logic tick_q;
    logic collide;
    logic time_hit;
    logic time_wr;
    logic ctrl_wr;
    logic stat_wr;

    // Decode write targets and the collision window
    always_comb begin
        time_hit = 1'b0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ADDR_W'(i))
                time_hit = 1'b1;
        end
        collide = tick || tick_q;
        time_wr = wr_en && time_hit && !page;
        ctrl_wr = wr_en && (addr == ADR_CTRL);
        stat_wr = wr_en && (addr == ADR_STAT);
    end

    // Per-field load strobes, blocked inside the collision window
    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++) begin
            field_load[i] = time_wr && !collide && (addr == ADDR_W'(i));
        end
    end

    // Delay the tick by one cycle to extend the collision window
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_q <= 1'b0;
        else
            tick_q <= tick;
    end

    // Control register: clear bit self-clears, mask and page are held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_clr <= 1'b0;
            irq_mask  <= 1'b1;
            page      <= 1'b0;
        end else begin
            presc_clr <= ctrl_wr && wdata[CTL_CLR];
            if (ctrl_wr) begin
                irq_mask <= wdata[CTL_MASK];
                page     <= wdata[CTL_PAGE];
            end
        end
    end

    // Pending flag: set by tick, cleared by writing 1, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (tick)
            pend <= 1'b1;
        else if (stat_wr && wdata[STS_PEND])
            pend <= 1'b0;
    end

    // Dropped-write flag: set by a colliding time write, cleared by writing 1
    always_ff @(posedge clk) begin
        if (!rst_n)
            drop <= 1'b0;
        else if (time_wr && collide)
            drop <= 1'b1;
        else if (stat_wr && wdata[STS_DROP])
            drop <= 1'b0;
    end

    // Read data multiplexer
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ADDR_W'(i) && !page)
                rdata = fields[i];
        end
        if (addr == ADR_CTRL)
            rdata = {{(DATA_W-3){1'b0}}, page, irq_mask, presc_clr};
        if (addr == ADR_STAT)
            rdata = {{(DATA_W-2){1'b0}}, drop, pend};
    end

endmodule

// File: rtl/rtc_core.sv
// Module: top of the real-time-clock core. Joins the prescaler, the time
// fields and the register bank; drives the level interrupt.
// Assumes clk_en pulses at 32.768 kHz when PRESC_BITS is 15.
module rtc_core
    import rtc_pkg::*;
#(
    parameter int PRESC_BITS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic                   tick;
    logic                   presc_clr;
    logic [PRESC_BITS-1:0]  presc_cnt;
    logic                   irq_mask;
    logic                   page;
    logic                   pend;
    logic                   drop;
    logic [NUM_FIELDS-1:0]  field_load;
    bcd8_t [NUM_FIELDS-1:0] fields;

    rtc_prescaler #(
        .PRESC_BITS(PRESC_BITS)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clk_en(clk_en),
        .clr   (presc_clr),
        .tick  (tick),
        .cnt   (presc_cnt)
    );

    rtc_timekeeper u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (field_load),
        .load_val(wdata),
        .fields  (fields)
    );

    rtc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .tick      (tick),
        .fields    (fields),
        .presc_clr (presc_clr),
        .irq_mask  (irq_mask),
        .page      (page),
        .pend      (pend),
        .drop      (drop),
        .field_load(field_load),
        .rdata     (rdata)
    );

    // Interrupt request while pending and unmasked
    always_comb begin
        irq = pend && !irq_mask;
    end

endmodule

// File: rtl/rtc_core_chk.sv
// Module: assertion checker for rtc_core, attached by bind below.
// Assumes the internal names of rtc_core stay stable.
module rtc_core_chk
    import rtc_pkg::*;
#(
    parameter int PRESC_BITS = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clk_en,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     addr,
    input logic                  wdata_clr,
    input logic                  irq,
    input logic                  tick,
    input logic                  presc_clr,
    input logic [PRESC_BITS-1:0] presc_cnt,
    input logic                  pend,
    input logic                  irq_mask,
    input logic                  page,
    input logic                  drop,
    input bcd8_t                 sec
);

    // R2
    presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !presc_clr) |=> $stable(presc_cnt));

    // R3
    clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_clr && !(wr_en && addr == ADR_CTRL && wdata_clr)) |=> !presc_clr);

    // R3
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        presc_clr |=> (presc_cnt == '0));

    // R4
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sec == 8'h59) |=> (sec == 8'h00));

    // R5
    tick_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pend);

    // R6
    tick_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (irq == !irq_mask));

    // R8
    drop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wr_en && addr < ADDR_W'(NUM_FIELDS) && !page) |=> drop);

endmodule

bind rtc_core rtc_core_chk #(
    .PRESC_BITS(PRESC_BITS)
) u_rtc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata_clr(wdata[0]),
    .irq      (irq),
    .tick     (tick),
    .presc_clr(presc_clr),
    .presc_cnt(presc_cnt),
    .pend     (pend),
    .irq_mask (irq_mask),
    .page     (page),
    .drop     (drop),
    .sec      (fields[0])
);

// File: tb/rtc_core_test.sv
`timescale 1ns/1ps
module rtc_core_test;

    localparam int PB = 4;  // 16 enables per second, midpoint after 8

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    rtc_core #(.PRESC_BITS(PB)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .clk_en(clk_en),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    always #2.5 clk = ~clk;

    // {sec, min, hour, expected sec, min, hour after one tick}
    localparam logic [47:0] VEC [8] = '{
        {8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00},
        {8'h09, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00},
        {8'h59, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00},
        {8'h59, 8'h59, 8'h00, 8'h00, 8'h00, 8'h01},
        {8'h59, 8'h59, 8'h23, 8'h00, 8'h00, 8'h00},
        {8'h56, 8'h34, 8'h12, 8'h57, 8'h34, 8'h12},
        {8'h59, 8'h59, 8'h19, 8'h00, 8'h00, 8'h20},
        {8'h59, 8'h09, 8'h05, 8'h00, 8'h10, 8'h05}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // Called at a negedge; reads without consuming a clock
    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Called at a negedge; the write takes effect at the next posedge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Prescaler clear at edge W, returns at the negedge after tick edge W+9
    task automatic sync_tick();
        wr(3'd3, 8'h03);
        wait_edges(9);
    endtask

    task automatic check_reset_state(input string tag);
        logic [7:0] v;
        rd(3'd0, v); check({tag, " R1 sec"}, v, 8'h00);
        rd(3'd1, v); check({tag, " R1 min"}, v, 8'h00);
        rd(3'd2, v); check({tag, " R1 hour"}, v, 8'h00);
        rd(3'd3, v); check({tag, " R1 ctrl"}, v, 8'h02);
        rd(3'd4, v); check({tag, " R1 status"}, v, 8'h00);
        check({tag, " R1 irq"}, {7'd0, irq}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] v, s0, m0, h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_reset_state("start");

        // R3 half-second first tick, R2 period, R5 pending, R6 mask
        clk_en = 1'b1;
        wr(3'd3, 8'h03);                       // edge W
        rd(3'd3, v); check("R3 clear bit set", v, 8'h03);
        wait_edges(1);
        rd(3'd3, v); check("R3 clear bit self-clears", v, 8'h02);
        wait_edges(7);                          // after W+8
        rd(3'd0, v); check("R3 no tick before half period", v, 8'h00);
        rd(3'd4, v); check("R5 not pending before tick", v, 8'h00);
        wait_edges(1);                          // after W+9
        rd(3'd0, v); check("R3 first tick after half period", v, 8'h01);
        rd(3'd4, v); check("R5 pending with seconds step", v, 8'h01);
        check("R6 masked irq low", {7'd0, irq}, 8'h00);
        wr(3'd3, 8'h00);                        // unmask at W+10
        check("R6 irq high when unmasked", {7'd0, irq}, 8'h01);
        wait_edges(14);                         // after W+24
        rd(3'd0, v); check("R2 no tick before full period", v, 8'h01);
        wait_edges(1);                          // after W+25
        rd(3'd0, v); check("R2 tick after full period", v, 8'h02);
        wr(3'd4, 8'h01);
        rd(3'd4, v); check("R5 pending cleared by write 1", v, 8'h00);
        check("R6 irq low after clear", {7'd0, irq}, 8'h00);

        // R4 and R9: vector table of load values and next-tick results
        for (int i = 0; i < 8; i++) begin
            sync_tick();
            @(negedge clk);                     // after W+10
            wr(3'd0, VEC[i][47:40]);            // W+11
            wr(3'd1, VEC[i][39:32]);            // W+12
            wr(3'd2, VEC[i][31:24]);            // W+13
            rd(3'd0, v); check("R9 sec load", v, VEC[i][47:40]);
            rd(3'd2, v); check("R9 hour load", v, VEC[i][31:24]);
            wait_edges(12);                     // after W+25
            rd(3'd0, v); check("R4 sec after tick", v, VEC[i][23:16]);
            rd(3'd1, v); check("R4 min after tick", v, VEC[i][15:8]);
            rd(3'd2, v); check("R4 hour after tick", v, VEC[i][7:0]);
        end

        // R8 collision window, R9 legal commit
        wr(3'd4, 8'h03);
        sync_tick();                            // after W+9
        rd(3'd0, s0);
        wr(3'd0, 8'h45);                        // W+10, cycle after tick
        rd(3'd0, v); check("R8 post-tick write dropped", v, s0);
        rd(3'd4, v); check("R8 drop flag set", v & 8'h02, 8'h02);
        wr(3'd4, 8'h02);                        // W+11
        rd(3'd4, v); check("R8 drop flag cleared", v & 8'h02, 8'h00);
        wr(3'd0, 8'h20);                        // W+12
        rd(3'd0, v); check("R9 write outside window", v, 8'h20);
        rd(3'd4, v); check("R9 no drop flag", v & 8'h02, 8'h00);
        wait_edges(12);                         // after W+24
        wr(3'd0, 8'h45);                        // W+25, tick edge
        rd(3'd0, v); check("R8 tick-cycle write dropped", v, 8'h21);
        rd(3'd4, v); check("R8 drop flag set on tick", v & 8'h02, 8'h02);

        // R2 enable gating: no advance without clk_en
        clk_en = 1'b0;
        rd(3'd0, s0); rd(3'd1, m0); rd(3'd2, h0);
        wait_edges(50);
        rd(3'd0, v); check("R2 sec held without enable", v, s0);
        rd(3'd1, v); check("R2 min held without enable", v, m0);
        rd(3'd2, v); check("R2 hour held without enable", v, h0);

        // R7 page select
        wr(3'd3, 8'h06);
        rd(3'd3, v); check("R7 ctrl page readback", v, 8'h06);
        rd(3'd0, v); check("R7 time hidden on page 1", v, 8'h00);
        wr(3'd0, 8'h33);
        wr(3'd2, 8'h11);
        wr(3'd3, 8'h02);
        rd(3'd0, v); check("R7 sec write ignored on page 1", v, s0);
        rd(3'd2, v); check("R7 hour write ignored on page 1", v, h0);

        // R1 second reset from a non-zero state
        rst_n = 1'b0;
        wait_edges(2);
        rst_n = 1'b1;
        check_reset_state("rerun");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule